// File: doc/BRIEF.md
# ISDN B-Channel Timeslot Port (GCI / IDL Framing)

This block connects a single 8-bit voice sample to one bearer channel of a 2B+D serial frame. Each frame it sends one byte onto a shared serial line in the chosen bearer slot, and it collects one byte from the matching slot of the receive line. Two framings are supported. In the first (GCI-style), every data bit lasts two port-clock periods. In the second (IDL-style), every bit lasts one period, and a short sync pulse marks the frame.

A static level on `mode_sel` chooses the framing. It is accepted only after it has stayed unchanged across enough frame starts. A second static level, `chan_sel`, chooses the first or second bearer slot for both directions. The serial port clock and sync arrive as ordinary inputs and are sampled by the fast system clock `clk`. All serial timing comes from edges detected on `port_clk`. The transmit side provides a data bit together with an output-enable, which the surrounding pad logic uses to drive the shared line or release it. The receive side delivers a parallel byte with a one-cycle strobe.

Top module: `isdn_slot_port`

## Requirements
- R1: `mode_sel` = 0 selects the two-clocks-per-bit framing and `mode_sel` = 1 selects the one-clock-per-bit framing. The selection takes effect at the second consecutive frame start that sees the same level. A level change clears the selection until it is qualified again.
- R2: After reset, and during any frame whose framing is not yet qualified, `tx_oe` stays 0 and `rx_valid` never pulses. After reset `tx_oe` = 0 and `rx_valid` = 0.
- R3: `chan_sel` = 0 selects the first bearer slot (B1) and `chan_sel` = 1 selects the second (B2). It is captured at each frame start and applies to both transmit and receive.
- R4: In two-clock framing, rising port-clock edges are numbered 0 at the frame start. Transmit bit i (MSB first, i = 0..7) is placed on `tx_line` at rising edge 1+2i for B1, or 17+2i for B2. Each bit is held for two clock periods.
- R5: In two-clock framing, `tx_oe` rises at the slot's first rising edge. It falls after falling edge 16 (B1) or falling edge 32 (B2). It is 0 at every other time in the frame.
- R6: In two-clock framing, receive bit i (MSB first) is sampled from `rx_line` on the second rising edge of its bit period. These are rising edges 2+2i for B1 and 18+2i for B2.
- R7: In one-clock framing, transmit bit i is placed on `tx_line` at rising edge 1+i for B1, or 11+i for B2. `tx_oe` is high from that slot's first rising edge until falling edge 8 (B1) or falling edge 18 (B2). It is 0 elsewhere.
- R8: In one-clock framing, receive bit i (MSB first) is sampled on falling edge 1+i for B1, or 11+i for B2.
- R9: Once the last bit of a slot has been sampled, `rx_byte` takes the received byte and `rx_valid` pulses for exactly one `clk` cycle, once per qualified frame. `rx_byte` resets to 0. Data in the unselected slot has no effect on `rx_byte`.
- R10: `tx_byte` is captured at the frame-start edge. Changes to it later in the frame do not alter the bits sent in that frame.
- R11: A frame starts at a rising port-clock edge where `port_sync` is 1 and was 0 at the previous rising edge. A sync pulse that stays high for several clocks starts only one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_clk | input | 1 | Serial port bit/data clock, synchronous to `clk` |
| port_sync | input | 1 | Frame sync, sampled on rising port-clock edges |
| mode_sel | input | 1 | Static framing select: 0 two-clock bits, 1 one-clock bits |
| chan_sel | input | 1 | Static bearer slot select: 0 B1, 1 B2 |
| rx_line | input | 1 | Serial receive data |
| tx_byte | input | BYTE_W | Byte to send in the next frame |
| tx_line | output | 1 | Serial transmit data, meaningful while `tx_oe` is 1 |
| tx_oe | output | 1 | Transmit drive enable; 0 means the line is released |
| rx_byte | output | BYTE_W | Last byte received from the selected slot |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 6-bit edge counter, a two-frame hold for mode qualification, and a two-clock gap before the second slot in one-clock framing. With these values both framings fit in a 40-clock frame, so the B2 release at falling edge 32 and the B2 start at rising edge 11 can be checked edge by edge. A deliberate one-frame mode glitch shows the requalification delay.

// File: rtl/isdn_slot_pkg.sv
// Shared types for the ISDN bearer timeslot port.
package isdn_slot_pkg;

    // Framing selected by the static mode level.
    typedef enum logic {
        FRM_TWO_CLK = 1'b0,   // each data bit spans two port clocks
        FRM_ONE_CLK = 1'b1    // each data bit spans one port clock
    } framing_e;

endpackage

// File: rtl/isdn_edge_track.sv
// Port clock edge tracker.
// Detects rising and falling edges of the port clock in the clk domain.
// Finds the frame start and numbers the rising edges since that start.
// Assumes port_clk and port_sync are already synchronous to clk.
// Assumes each port clock phase lasts at least two clk cycles.
// Assumes port_clk is low while reset is asserted.
module isdn_edge_track #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_clk,
    input  logic             port_sync,
    output logic             rise,
    output logic             fall,
    output logic             frame_start,
    output logic [CNT_W-1:0] edge_idx
);

    localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};

    logic             pclk_q;
    logic             sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] next_idx;

    // Edge strobes and the index of the current edge.
    always_comb begin
        rise        = port_clk & ~pclk_q;
        fall        = ~port_clk & pclk_q;
        frame_start = rise & port_sync & ~sync_q;
        if (frame_start)
            next_idx = '0;
        else if (cnt_q == IDX_MAX)
            next_idx = cnt_q;
        else
            next_idx = cnt_q + 1'b1;
        edge_idx = rise ? next_idx : cnt_q;
    end

    // Delay the port clock and count rising edges, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q <= 1'b0;
            sync_q <= 1'b0;
            cnt_q  <= IDX_MAX;
        end else begin
            pclk_q <= port_clk;
            if (rise) begin
                sync_q <= port_sync;
                cnt_q  <= next_idx;
            end
        end
    end

    // A frame start restarts the numbering at zero.
    assert_start_zeroes_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (edge_idx == '0));

    // A held-high sync must not start a second frame on the next rising edge.
    assert_one_start_per_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && sync_q && port_sync) |-> !frame_start);

endmodule

// File: rtl/isdn_mode_qual.sv
// Framing mode qualifier.
// Accepts the static mode level once it has been seen unchanged at
// HOLD_FRAMES consecutive frame starts. Any change of the level clears the
// qualification at once.
// Assumes mode_sel is synchronous to clk.
module isdn_mode_qual
    import isdn_slot_pkg::*;
#(
    parameter int HOLD_FRAMES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_start,
    input  logic     mode_sel,
    output logic     mode_ok,
    output framing_e mode
);

    localparam int               RUN_W   = $clog2(HOLD_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_FRAMES);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             held_q;
    logic             ok_q;

    // Length of the run of frames with an unchanged level.
    always_comb begin
        if (mode_sel == held_q && run_q != '0)
            run_nx = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        else
            run_nx = RUN_ONE;
    end

    // Update the run at frame starts; drop qualification on any level change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            held_q <= 1'b0;
            ok_q   <= 1'b0;
        end else if (frame_start) begin
            run_q  <= run_nx;
            held_q <= mode_sel;
            ok_q   <= (run_nx == RUN_MAX);
        end else if (mode_sel != held_q) begin
            run_q  <= '0;
            ok_q   <= 1'b0;
        end
    end

    assign mode_ok = ok_q;
    assign mode    = framing_e'(held_q);

    // Qualification can only begin at a frame start.
    assert_ok_rises_at_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_ok) |-> $past(frame_start));

    // A level change outside a frame start removes qualification on the next cycle.
    assert_change_drops_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && mode_ok && (mode_sel != held_q)) |=> !mode_ok);

endmodule

// File: rtl/isdn_slot_engine.sv
// Bearer slot engine.
// Places the transmit byte into the selected slot and collects the receive
// byte from the same slot, using the edge strobes and edge numbers from the
// edge tracker. The slot position, bit length and receive edge depend on the
// framing. Assumes CNT_W holds 1 + 4*BYTE_W so that every slot edge is
// counted before the counter saturates.
module isdn_slot_engine
    import isdn_slot_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CNT_W   = 6,
    parameter int IDL_GAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              frame_start,
    input  logic [CNT_W-1:0]  edge_idx,
    input  logic              mode_ok,
    input  framing_e          mode,
    input  logic              chan_sel,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_line,
    output logic              tx_line,
    output logic              tx_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam logic [CNT_W-1:0] FIRST_B1     = CNT_W'(1);
    localparam logic [CNT_W-1:0] ONE_FIRST_B2 = CNT_W'(1 + BYTE_W + IDL_GAP);
    localparam logic [CNT_W-1:0] TWO_FIRST_B2 = CNT_W'(1 + 2 * BYTE_W);
    localparam logic [CNT_W-1:0] ONE_SPAN     = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TWO_SPAN     = CNT_W'(2 * BYTE_W);

    logic              chan_q;
    logic [BYTE_W-1:0] txbuf_q;
    logic [BYTE_W-1:0] txsh_q;
    logic              oe_q;
    logic [BYTE_W-1:0] rxsh_q;
    logic [BYTE_W-1:0] rxbyte_q;
    logic              valid_q;

    logic              one_clk;
    logic [CNT_W-1:0]  first;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  d;
    logic              in_win;
    logic              tx_step;
    logic              tx_load;
    logic              oe_end;
    logic              rx_smp;
    logic              rx_last;

    // Slot window of the current edge for the latched framing and slot.
    always_comb begin
        one_clk = (mode == FRM_ONE_CLK);
        if (one_clk) begin
            first = chan_q ? ONE_FIRST_B2 : FIRST_B1;
            span  = ONE_SPAN;
        end else begin
            first = chan_q ? TWO_FIRST_B2 : FIRST_B1;
            span  = TWO_SPAN;
        end
        d      = edge_idx - first;
        in_win = (edge_idx >= first) && (d < span);
    end

    // Event strobes for transmit steps, release and receive samples.
    always_comb begin
        tx_step = rise && !frame_start && mode_ok && in_win && (one_clk || !d[0]);
        tx_load = tx_step && (d == '0);
        oe_end  = fall && in_win && (d == span - 1'b1);
        if (one_clk)
            rx_smp = fall && mode_ok && in_win;
        else
            rx_smp = rise && !frame_start && mode_ok && in_win && d[0];
        rx_last = rx_smp && (d == span - 1'b1);
    end

    // Capture the slot select and transmit byte at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= 1'b0;
            txbuf_q <= '0;
        end else if (frame_start) begin
            chan_q  <= chan_sel;
            txbuf_q <= tx_byte;
        end
    end

    // Shift the transmit byte out MSB first and control the line enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsh_q <= '0;
            oe_q   <= 1'b0;
        end else if (frame_start) begin
            oe_q   <= 1'b0;
        end else if (tx_load) begin
            txsh_q <= txbuf_q;
            oe_q   <= 1'b1;
        end else if (tx_step) begin
            txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
        end else if (oe_end) begin
            oe_q   <= 1'b0;
        end
    end

    // Shift receive bits in MSB first and publish the byte after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxsh_q   <= '0;
            rxbyte_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (rx_smp)
                rxsh_q <= {rxsh_q[BYTE_W-2:0], rx_line};
            if (rx_last) begin
                rxbyte_q <= {rxsh_q[BYTE_W-2:0], rx_line};
                valid_q  <= 1'b1;
            end
        end
    end

    assign tx_line  = txsh_q[BYTE_W-1];
    assign tx_oe    = oe_q & mode_ok;
    assign rx_byte  = rxbyte_q;
    assign rx_valid = valid_q;

    // The line enable switches on only at a rising port-clock edge.
    assert_oe_starts_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> $past(rise));

    // Transmit data moves only at rising port-clock edges.
    assert_line_moves_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(tx_line));

    // The enable is released at a falling edge, at a frame start, or with a loss of qualification.
    assert_oe_ends_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> ($past(fall) || $past(frame_start) || !mode_ok));

    // The receive strobe lasts one cycle.
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // No receive strobe without a qualified framing.
    assert_valid_needs_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(mode_ok));

endmodule

// File: rtl/isdn_slot_port.sv
// ISDN bearer timeslot port, top level.
// Ties together the edge tracker, the framing qualifier and the slot engine.
// Assumes all inputs are synchronous to clk, and that the port clock is
// slower than clk, with each phase lasting at least two clk cycles.
module isdn_slot_port
    import isdn_slot_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int CNT_W       = 6,
    parameter int HOLD_FRAMES = 2,
    parameter int IDL_GAP     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_clk,
    input  logic              port_sync,
    input  logic              mode_sel,
    input  logic              chan_sel,
    input  logic              rx_line,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_line,
    output logic              tx_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    logic             rise;
    logic             fall;
    logic             frame_start;
    logic [CNT_W-1:0] edge_idx;
    logic             mode_ok;
    framing_e         mode;

    isdn_edge_track #(
        .CNT_W (CNT_W)
    ) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_clk    (port_clk),
        .port_sync   (port_sync),
        .rise        (rise),
        .fall        (fall),
        .frame_start (frame_start),
        .edge_idx    (edge_idx)
    );

    isdn_mode_qual #(
        .HOLD_FRAMES (HOLD_FRAMES)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mode_sel    (mode_sel),
        .mode_ok     (mode_ok),
        .mode        (mode)
    );

    isdn_slot_engine #(
        .BYTE_W  (BYTE_W),
        .CNT_W   (CNT_W),
        .IDL_GAP (IDL_GAP)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .fall        (fall),
        .frame_start (frame_start),
        .edge_idx    (edge_idx),
        .mode_ok     (mode_ok),
        .mode        (mode),
        .chan_sel    (chan_sel),
        .tx_byte     (tx_byte),
        .rx_line     (rx_line),
        .tx_line     (tx_line),
        .tx_oe       (tx_oe),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid)
    );

endmodule

// File: tb/isdn_slot_port_bench.sv
// Scoreboard bench for the ISDN bearer timeslot port.
module isdn_slot_port_bench;

    localparam int BW = 8;
    localparam int FL = 40;   // port clocks per frame

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_clk = 1'b0;
    logic          port_sync = 1'b0;
    logic          mode_sel = 1'b0;
    logic          chan_sel = 1'b0;
    logic          rx_line = 1'b1;
    logic [BW-1:0] tx_byte = '0;
    logic          tx_line;
    logic          tx_oe;
    logic [BW-1:0] rx_byte;
    logic          rx_valid;

    isdn_slot_port u_isdn_slot_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_clk  (port_clk),
        .port_sync (port_sync),
        .mode_sel  (mode_sel),
        .chan_sel  (chan_sel),
        .rx_line   (rx_line),
        .tx_byte   (tx_byte),
        .tx_line   (tx_line),
        .tx_oe     (tx_oe),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit    oe;
        bit    line;
        int    k;
        string tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [BW-1:0] rxexp_q[$];
    string         rxtag_q[$];
    event          smp_ev;
    int            checks = 0;
    int            fails = 0;
    int            rx_seen = 0;
    bit            done = 1'b0;
    bit            have_prev = 1'b0;
    bit            prev_m = 1'b0;
    int            run = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compare the line state with each queued expectation.
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(tx_oe == e.oe, $sformatf("%s oe k=%0d", e.tag, e.k), int'(tx_oe), int'(e.oe));
                if (e.oe)
                    check(tx_line == e.line, $sformatf("%s data k=%0d", e.tag, e.k),
                          int'(tx_line), int'(e.line));
            end
        end
    end

    // Monitor: every receive strobe must match a queued byte.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_seen++;
            if (rxexp_q.size() == 0)
                check(1'b0, "R2 unexpected rx_valid", 1, 0);
            else begin
                string t;
                logic [BW-1:0] x;
                x = rxexp_q.pop_front();
                t = rxtag_q.pop_front();
                check(rx_byte == x, t, int'(rx_byte), int'(x));
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Push one expectation, trigger the monitor, finish the phase.
    task automatic sample(input bit oe, input bit line, input int k, input string tag);
        exp_t e;
        e.oe = oe; e.line = line; e.k = k; e.tag = tag;
        exp_q.push_back(e);
        ->smp_ev;
        wait_n(1);
    endtask

    // Port clocks with no sync: the line must stay released.
    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            port_clk = 1'b1;
            wait_n(3);
            sample(1'b0, 1'b0, i, "R2 idle");
            port_clk = 1'b0;
            wait_n(3);
            sample(1'b0, 1'b0, i, "R2 idle");
        end
    endtask

    // Drive one frame; compute the expected line and receive byte from the requirements.
    task automatic run_frame(input bit m, input bit c, input logic [BW-1:0] txb,
                             input logic [BW-1:0] rxb, input int sync_len);
        bit    active;
        int    first, ofirst, stride, span;
        string note, hi_tag, lo_tag;
        if (have_prev && m == prev_m) run++;
        else run = 1;
        have_prev = 1'b1;
        prev_m    = m;
        active    = (run >= 2);
        stride    = m ? 1 : 2;
        span      = 8 * stride;
        first     = m ? (c ? 11 : 1) : (c ? 17 : 1);
        ofirst    = m ? (c ? 1 : 11) : (c ? 1 : 17);
        note      = "";
        if (run == 2) note = {note, " R1"};
        if (c) note = {note, " R3-B2"};
        else note = {note, " R3-B1"};
        if (sync_len > 1) note = {note, " R11"};
        hi_tag = active ? {(m ? "R7" : "R4"), " R10", note} : {"R2", note};
        lo_tag = active ? {(m ? "R7" : "R5"), note} : {"R2", note};
        rx_seen = 0;
        if (active) begin
            rxexp_q.push_back(rxb);
            rxtag_q.push_back({(m ? "R8" : "R6"), " R9", note});
        end
        mode_sel  = m;
        chan_sel  = c;
        tx_byte   = txb;
        port_sync = 1'b1;
        for (int k = 0; k < FL; k++) begin
            int  d, od;
            bit  in_hi, in_lo;
            bit  bitv;
            d  = k - first;
            od = k - ofirst;
            if (d >= 0 && d < span) rx_line = rxb[7 - d / stride];
            else if (od >= 0 && od < span) rx_line = ~rxb[7 - od / stride];
            else rx_line = 1'b1;
            port_clk = 1'b1;
            wait_n(3);
            in_hi = active && d >= 0 && d < span;
            in_lo = active && d >= 0 && d < span - 1;
            bitv  = (d >= 0 && d < span) ? txb[7 - d / stride] : 1'b0;
            sample(in_hi, bitv, k, hi_tag);
            if (k == 1) tx_byte = ~txb;
            port_clk = 1'b0;
            if (k == sync_len - 1) port_sync = 1'b0;
            wait_n(3);
            sample(in_lo, bitv, k, lo_tag);
        end
        check(rx_seen == (active ? 1 : 0), {"R9 strobe count", note}, rx_seen, active ? 1 : 0);
    endtask

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        check(tx_oe == 1'b0, "R2 reset tx_oe", int'(tx_oe), 0);
        check(rx_valid == 1'b0, "R2 reset rx_valid", int'(rx_valid), 0);
        check(rx_byte == '0, "R9 reset rx_byte", int'(rx_byte), 0);
        idle_ticks(3);
        // Two-clock framing: qualification, B1, B2, long sync.
        run_frame(1'b0, 1'b0, 8'hA5, 8'h3C, 1);
        run_frame(1'b0, 1'b0, 8'hA5, 8'h3C, 1);
        run_frame(1'b0, 1'b1, 8'h96, 8'hC3, 1);
        run_frame(1'b0, 1'b1, 8'h5B, 8'h81, 2);
        run_frame(1'b0, 1'b0, 8'h00, 8'hFF, 2);
        // One-clock framing: requalification, B1, B2.
        run_frame(1'b1, 1'b0, 8'h71, 8'h4E, 1);
        run_frame(1'b1, 1'b0, 8'h71, 8'h4E, 1);
        run_frame(1'b1, 1'b1, 8'hD2, 8'h2D, 1);
        run_frame(1'b1, 1'b1, 8'hFF, 8'h00, 3);
        run_frame(1'b1, 1'b0, 8'h81, 8'h7E, 1);
        // One-frame glitch on the mode level forces requalification.
        run_frame(1'b0, 1'b1, 8'h33, 8'hCC, 1);
        run_frame(1'b1, 1'b1, 8'h69, 8'h96, 1);
        run_frame(1'b1, 1'b1, 8'h69, 8'h96, 1);
        run_frame(1'b0, 1'b0, 8'h12, 8'hED, 1);
        run_frame(1'b0, 1'b0, 8'hE4, 8'h1B, 1);
        idle_ticks(2);
        wait_n(4);
        check(rxexp_q.size() == 0, "R9 all receive bytes delivered", rxexp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule